// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a four-word register window that lets a host processor hand numbered commands to a companion microcontroller and collect what comes back. The host loads up to two argument words, then writes an 8-bit command number to the status/command word. That write raises a busy flag and sends a one-cycle strobe to the controller, which carries the command number and both arguments. The host then polls the busy flag until it drops. No interrupt is needed for this.

When the controller finishes, it pulses a done input with an error flag and two result words. In that same cycle the block clears busy, latches the error flag, and overwrites both data words. After a success the data words hold results. After a failure they hold the error code in the first word. Completion can also raise an interrupt-pending flag. The host clears that flag by writing the version word, and reading the version word returns a fixed identification value. Host accesses are single-cycle and synchronous, and read data appears one cycle after the read request.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the status word, both data words, the command strobe and the interrupt output are all zero.
- R2: A write to byte offset 0x0 while not busy sets busy (status bit 31), clears the error bit (bit 30) and records wdata[7:0] in status bits 7:0. On the following cycle the command strobe is high for exactly one cycle, with that ID and the current data words as arguments.
- R3: A write to offset 0x0 while busy is ignored: no strobe is produced and status bits 7:0 keep the running command's ID.
- R4: While not busy, writes to offsets 0x4 and 0x8 update the first and second data words, and those values read back.
- R5: While busy, host writes to offsets 0x4 and 0x8 leave the data words unchanged.
- R6: A done pulse while busy clears busy, copies the error flag into status bit 30, and loads both data words from the result inputs, all in the same cycle.
- R7: A done pulse while not busy changes neither the status word nor the data words.
- R8: With interrupts enabled, an accepted completion sets the pending flag (status bit 29 and the interrupt output). A write to offset 0xC clears it, and a completion in the same cycle as that write wins.
- R9: A read request returns, on the next cycle, the addressed word: offset 0xC gives the VERSION parameter, and status bits 28:8 read as zero. The read data holds while no read is requested.
- R10: With interrupts disabled, the pending flag and status bit 29 stay zero.
- R11: An access whose address has nonzero bits 1:0, or any nonzero bit above bit 3, is ignored, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_we | input | 1 | Host write request |
| host_re | input | 1 | Host read request |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| ctl_cmd_valid | output | 1 | One-cycle command launch strobe |
| ctl_cmd_id | output | ID_W | Command number |
| ctl_arg0 | output | DATA_W | First argument / current first data word |
| ctl_arg1 | output | DATA_W | Second argument / current second data word |
| ctl_done | input | 1 | Completion pulse from the controller |
| ctl_err | input | 1 | Completion failed |
| ctl_res0 | input | DATA_W | First result word or error code |
| ctl_res1 | input | DATA_W | Second result word |
| host_irq | output | 1 | Interrupt-pending flag |

## Verification
The bench builds two copies side by side. The first has interrupts enabled and a 6-bit address, so the decoder's check on the upper address bits is really built and exercised. The second has interrupts disabled, which shows that the pending flag never rises. Both copies run the same directed and random traffic. That traffic includes launches while busy, data writes during a command, completions while idle, and a clear landing in the same cycle as a completion.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int unsigned NUM_DATA = 2;

   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_D0   = 2'd1,
      SEL_D1   = 2'd2,
      SEL_VER  = 2'd3
   } mbx_sel_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output logic              hit,
   output mbx_sel_e          sel,
   output logic              wr_cmd,
   output logic              wr_ver,
   output logic [NUM_DATA-1:0] wr_word,
   output logic              rd_hit
);

   logic up_ok;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("mbx_decode: ADDR_W must be at least 4");
   end

   if (ADDR_W > 4) begin : g_upper
      assign up_ok = ~|addr[ADDR_W-1:4];
   end else begin : g_exact
      assign up_ok = 1'b1;
   end

   assign hit    = up_ok && (addr[1:0] == 2'b00);
   assign sel    = mbx_sel_e'(addr[3:2]);
   assign wr_cmd = we && hit && (sel == SEL_STAT);
   assign wr_ver = we && hit && (sel == SEL_VER);
   assign rd_hit = re && hit;

   for (genvar i = 0; i < NUM_DATA; i++) begin : g_wsel
      assign wr_word[i] = we && hit && (addr[3:2] == 2'(i + 1));
   end

endmodule

// File: rtl/mbx_cmd_ctrl.sv
module mbx_cmd_ctrl #(
   parameter int unsigned ID_W       = 8,
   parameter bit          IRQ_ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_cmd,
   input  logic            wr_irq_clr,
   input  logic [ID_W-1:0] id_in,
   input  logic            done,
   input  logic            err_in,
   output logic            busy,
   output logic            err,
   output logic            irq_pend,
   output logic [ID_W-1:0] last_id,
   output logic            cmd_valid,
   output logic            accept
);

   logic launch;

   assign launch = wr_cmd && !busy;
   assign accept = done && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         err       <= 1'b0;
         last_id   <= '0;
         cmd_valid <= 1'b0;
      end else begin
         cmd_valid <= launch;
         if (launch) begin
            busy    <= 1'b1;
            err     <= 1'b0;
            last_id <= id_in;
         end else if (accept) begin
            busy <= 1'b0;
            err  <= err_in;
         end
      end
   end

   if (IRQ_ENABLE) begin : g_irq
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_pend <= 1'b0;
         end else if (accept) begin
            irq_pend <= 1'b1;
         end else if (wr_irq_clr) begin
            irq_pend <= 1'b0;
         end
      end
   end else begin : g_noirq
      logic unused_clr;
      assign unused_clr = wr_irq_clr;
      assign irq_pend   = 1'b0;
   end

endmodule

// File: rtl/mbx_data_bank.sv
module mbx_data_bank
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_DATA-1:0] wr_word,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              load,
   input  logic [DATA_W-1:0] res_in [NUM_DATA],
   output logic [DATA_W-1:0] data_q [NUM_DATA]
);

   for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q[i] <= '0;
         end else if (load) begin
            data_q[i] <= res_in[i];
         end else if (wr_word[i] && !busy) begin
            data_q[i] <= wdata;
         end
      end
   end

endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic              re,
   input  mbx_sel_e          sel,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] data_q [NUM_DATA],
   input  logic [DATA_W-1:0] version,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mux;

   always_comb begin
      unique case (sel)
         SEL_STAT: mux = status;
         SEL_D0:   mux = data_q[0];
         SEL_D1:   mux = data_q[1];
         default:  mux = version;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= rd_hit ? mux : '0;
      end
   end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ID_W       = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          IRQ_ENABLE = 1'b1,
   parameter logic [31:0] VERSION    = 32'h4D42_0103
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_we,
   input  logic              host_re,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              ctl_cmd_valid,
   output logic [ID_W-1:0]   ctl_cmd_id,
   output logic [DATA_W-1:0] ctl_arg0,
   output logic [DATA_W-1:0] ctl_arg1,
   input  logic              ctl_done,
   input  logic              ctl_err,
   input  logic [DATA_W-1:0] ctl_res0,
   input  logic [DATA_W-1:0] ctl_res1,
   output logic              host_irq
);

   localparam int unsigned FLAG_W = 3;
   localparam int unsigned PAD_W  = DATA_W - FLAG_W - ID_W;

   if (DATA_W != 32) begin : g_bad_dw
      $error("cmd_mailbox: DATA_W must be 32");
   end
   if (ID_W < 1 || ID_W > DATA_W - FLAG_W - 1) begin : g_bad_id
      $error("cmd_mailbox: ID_W out of range");
   end

   logic                  hit_s, wr_cmd_s, wr_ver_s, rd_hit_s;
   mbx_sel_e              sel_s;
   logic [NUM_DATA-1:0]   wr_word_s;
   logic                  busy_s, err_s, irq_s, accept_s;
   logic [ID_W-1:0]       id_s;
   logic [DATA_W-1:0]     status_s;
   logic [DATA_W-1:0]     data_s [NUM_DATA];
   logic [DATA_W-1:0]     res_s  [NUM_DATA];
   logic                  unused_hit;

   assign unused_hit = hit_s;
   assign res_s[0]   = ctl_res0;
   assign res_s[1]   = ctl_res1;

   mbx_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (host_addr),
      .we      (host_we),
      .re      (host_re),
      .hit     (hit_s),
      .sel     (sel_s),
      .wr_cmd  (wr_cmd_s),
      .wr_ver  (wr_ver_s),
      .wr_word (wr_word_s),
      .rd_hit  (rd_hit_s)
   );

   mbx_cmd_ctrl #(.ID_W(ID_W), .IRQ_ENABLE(IRQ_ENABLE)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cmd     (wr_cmd_s),
      .wr_irq_clr (wr_ver_s),
      .id_in      (host_wdata[ID_W-1:0]),
      .done       (ctl_done),
      .err_in     (ctl_err),
      .busy       (busy_s),
      .err        (err_s),
      .irq_pend   (irq_s),
      .last_id    (id_s),
      .cmd_valid  (ctl_cmd_valid),
      .accept     (accept_s)
   );

   mbx_data_bank #(.DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_word (wr_word_s),
      .wdata   (host_wdata),
      .busy    (busy_s),
      .load    (accept_s),
      .res_in  (res_s),
      .data_q  (data_s)
   );

   assign status_s = {busy_s, err_s, irq_s, {PAD_W{1'b0}}, id_s};

   mbx_rdmux #(.DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_hit  (rd_hit_s),
      .re      (host_re),
      .sel     (sel_s),
      .status  (status_s),
      .data_q  (data_s),
      .version (VERSION[DATA_W-1:0]),
      .rdata   (host_rdata)
   );

   assign ctl_cmd_id = id_s;
   assign ctl_arg0   = data_s[0];
   assign ctl_arg1   = data_s[1];
   assign host_irq   = irq_s;

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter bit          IRQ_ENABLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_cmd,
   input logic              busy,
   input logic              done,
   input logic              cmd_valid,
   input logic              irq,
   input logic [1:0]        wr_word,
   input logic [DATA_W-1:0] d0,
   input logic [DATA_W-1:0] d1
);

   // R2
   launch_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd && !busy |=> busy && cmd_valid);

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R3
   busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd && busy |=> !cmd_valid);

   // R5
   data_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(d0) && $stable(d1));

   // R6
   done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && busy |=> !busy);

   // R7
   idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !busy && (wr_word == 2'b00) |=> $stable(d0) && $stable(d1));

   // R8
   irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      IRQ_ENABLE && done && busy |=> irq);

   // R10
   irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !IRQ_ENABLE |-> !irq);

endmodule

bind cmd_mailbox mbx_chk #(.DATA_W(DATA_W), .IRQ_ENABLE(IRQ_ENABLE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_cmd    (wr_cmd_s),
   .busy      (busy_s),
   .done      (ctl_done),
   .cmd_valid (ctl_cmd_valid),
   .irq       (host_irq),
   .wr_word   (wr_word_s),
   .d0        (ctl_arg0),
   .d1        (ctl_arg1)
);

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;

   localparam logic [31:0] VER = 32'h4D42_0103;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [31:0] wdata = '0;
   logic        done = 1'b0, derr = 1'b0;
   logic [31:0] res0 = '0, res1 = '0;

   logic [31:0] rd0, rd1, a0_0, a1_0, a0_1, a1_1;
   logic        cv0, cv1, irq0, irq1;
   logic [7:0]  cid0, cid1;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic        m_busy = 1'b0, m_err = 1'b0, m_irq = 1'b0;
   logic [7:0]  m_id = '0;
   logic [31:0] m_d0 = '0, m_d1 = '0, m_rd = '0;

   always #5 clk = ~clk;

   cmd_mailbox #(.ADDR_W(6), .IRQ_ENABLE(1'b1), .VERSION(VER)) u0 (
      .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_we(we), .host_re(re),
      .host_wdata(wdata), .host_rdata(rd0), .ctl_cmd_valid(cv0), .ctl_cmd_id(cid0),
      .ctl_arg0(a0_0), .ctl_arg1(a1_0), .ctl_done(done), .ctl_err(derr),
      .ctl_res0(res0), .ctl_res1(res1), .host_irq(irq0));

   cmd_mailbox #(.ADDR_W(6), .IRQ_ENABLE(1'b0), .VERSION(VER)) u1 (
      .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_we(we), .host_re(re),
      .host_wdata(wdata), .host_rdata(rd1), .ctl_cmd_valid(cv1), .ctl_cmd_id(cid1),
      .ctl_arg0(a0_1), .ctl_arg1(a1_1), .ctl_done(done), .ctl_err(derr),
      .ctl_res0(res0), .ctl_res1(res1), .host_irq(irq1));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("[TB] FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic f_hit(input logic [5:0] a);
      return (a[5:4] == 2'b00) && (a[1:0] == 2'b00);
   endfunction

   function automatic logic [31:0] f_status(input logic irq_on);
      return {m_busy, m_err, m_irq & irq_on, 21'b0, m_id};
   endfunction

   function automatic logic [31:0] f_read(input logic [5:0] a);
      if (!f_hit(a)) return 32'h0;
      case (a[3:2])
         2'd0:    return f_status(1'b1);
         2'd1:    return m_d0;
         2'd2:    return m_d1;
         default: return VER;
      endcase
   endfunction

   // One clock: drive at negedge, predict, step, check at the next negedge.
   task automatic step(input logic w, input logic r, input logic [5:0] a,
                       input logic [31:0] d, input logic dn, input logic de,
                       input logic [31:0] r0, input logic [31:0] r1, input string tag);
      logic launch, acc, exp_rd1;
      logic [31:0] st_noirq;
      we = w; re = r; addr = a; wdata = d; done = dn; derr = de; res0 = r0; res1 = r1;
      launch   = w && f_hit(a) && (a[3:2] == 2'd0) && !m_busy;
      acc      = dn && m_busy;
      st_noirq = f_status(1'b0);
      exp_rd1  = r;
      if (r) m_rd = f_read(a);
      if (launch) begin
         m_busy = 1'b1; m_err = 1'b0; m_id = d[7:0];
      end else if (acc) begin
         m_busy = 1'b0; m_err = de; m_d0 = r0; m_d1 = r1;
      end
      if (w && f_hit(a) && !acc && !m_busy && !launch) begin
         if (a[3:2] == 2'd1) m_d0 = d;
         if (a[3:2] == 2'd2) m_d1 = d;
      end
      if (acc) m_irq = 1'b1;
      else if (w && f_hit(a) && (a[3:2] == 2'd3)) m_irq = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R9 rdata"}, rd0, m_rd);
      chk("R2 R3 strobe", {31'b0, cv0}, {31'b0, launch});
      if (launch) begin
         chk("R2 id", {24'b0, cid0}, {24'b0, m_id});
         chk("R2 args", a0_0 ^ {a1_0[15:0], a1_0[31:16]}, m_d0 ^ {m_d1[15:0], m_d1[31:16]});
      end
      chk("R8 irq", {31'b0, irq0}, {31'b0, m_irq});
      chk("R10 irq off", {31'b0, irq1}, 32'h0);
      if (exp_rd1 && f_hit(a) && a[3:2] == 2'd0) begin
         chk("R10 status bit29", rd1 & 32'h2000_0000, 32'h0);
         chk("R10 status rest", rd1 & 32'hDFFF_FFFF, st_noirq & 32'hDFFF_FFFF);
      end
      we = 1'b0; re = 1'b0; done = 1'b0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
      step(1'b1, 1'b0, a, d, 1'b0, 1'b0, '0, '0, tag);
   endtask

   task automatic rd(input logic [5:0] a, input string tag);
      step(1'b0, 1'b1, a, '0, 1'b0, 1'b0, '0, '0, tag);
   endtask

   task automatic fin(input logic e, input logic [31:0] r0, input logic [31:0] r1, input string tag);
      step(1'b0, 1'b0, '0, '0, 1'b1, e, r0, r1, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("[TB] FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'b0, irq0}, 32'h0);
      chk("R1 strobe", {31'b0, cv0}, 32'h0);
      rd(6'h00, "R1"); rd(6'h04, "R1"); rd(6'h08, "R1");
      // R4 data writes while idle
      wr(6'h04, 32'hA5A5_0001, "R4"); wr(6'h08, 32'h1234_5678, "R4");
      rd(6'h04, "R4"); rd(6'h08, "R4");
      // R2 launch
      wr(6'h00, 32'hFFFF_FF5A, "R2");
      rd(6'h00, "R2");
      // R3 relaunch ignored
      wr(6'h00, 32'h0000_0011, "R3");
      rd(6'h00, "R3");
      // R5 data writes ignored while busy
      wr(6'h04, 32'hDEAD_BEEF, "R5"); wr(6'h08, 32'hCAFE_F00D, "R5");
      rd(6'h04, "R5"); rd(6'h08, "R5");
      // R6 success completion, R8 irq set
      fin(1'b0, 32'h0000_0777, 32'h0000_0888, "R6");
      rd(6'h00, "R6"); rd(6'h04, "R6"); rd(6'h08, "R6");
      // R8 clear, R9 version
      wr(6'h0C, 32'h0, "R8");
      rd(6'h0C, "R9"); rd(6'h00, "R8");
      // R7 done while idle ignored
      fin(1'b1, 32'h1111_1111, 32'h2222_2222, "R7");
      rd(6'h00, "R7"); rd(6'h04, "R7");
      // R6 error completion
      wr(6'h00, 32'h0000_00C3, "R6");
      fin(1'b1, 32'h0000_00E5, 32'h0, "R6");
      rd(6'h00, "R6"); rd(6'h04, "R6");
      // R8 set wins over clear
      wr(6'h00, 32'h0000_0001, "R8");
      step(1'b1, 1'b0, 6'h0C, '0, 1'b1, 1'b0, 32'h5, 32'h6, "R8");
      rd(6'h00, "R8");
      // R11 misaligned and out-of-window accesses
      wr(6'h05, 32'h0BAD_0BAD, "R11"); wr(6'h24, 32'h0BAD_0BAD, "R11");
      wr(6'h11, 32'h0000_0099, "R11");
      rd(6'h04, "R11"); rd(6'h24, "R11"); rd(6'h00, "R11");
      // R9 hold while no read
      step(1'b0, 1'b0, 6'h08, '0, 1'b0, 1'b0, '0, '0, "R9");
      // Random traffic
      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         logic [5:0] a;
         logic w, r, dn;
         a  = ($urandom % 8 == 0) ? 6'($urandom) : {2'b00, 2'($urandom), 2'b00};
         w  = ($urandom % 3 == 0);
         r  = !w && ($urandom % 2 == 0);
         dn = ($urandom % 5 == 0);
         step(w, r, a, $urandom, dn, 1'($urandom), $urandom, $urandom, "RND");
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule